// File: doc/BRIEF.md
# Rail Sequencer and Reset Supervisor

This block decides when a board's supply domains may turn on and when the system may leave reset. It watches a shared bus and three dependent domains: management, core and IO. Bus health, per-domain in-window status and per-domain critical-fault status all arrive as synchronous digital flags. The block drives one enable per domain. It turns each domain's raw status into a filtered power-good and releases an active-low system reset only after every domain has settled.

Bring-up runs in a fixed order. Management starts first, and only while the bus is healthy. Core and IO start together once management is good. Every enabled domain has a blanking window, a stability interval and a bring-up timeout, each programmable in clock ticks. Several events force an ordered shutdown: a domain that never qualifies, a sustained power-good loss, a critical fault or a bus loss. The shutdown switches IO off first, then core, then management, with a fixed gap between steps. The block then retries bring-up a bounded number of times. When the retries run out it parks until an explicit clear.

Failures leave evidence. A one-cycle log pulse marks every shutdown and the final lock-out, and a fault code names the domain that timed out. A short dip of a good domain produces only a warning pulse.

Top module: `rail_seq_supervisor`

## Requirements
- R1: After reset, all enables, all power-good outputs and the aggregate are low. The system reset output is low (asserted), the fault code is 0 and neither pulse output is high.
- R2: The management enable rises only when the bus-healthy flag was high in the previous cycle. Core and IO enables rise together, one cycle after management power-good is seen.
- R3: A domain's power-good rises exactly blank + stable cycles after its enable rises, provided its in-window flag stays high and its critical flag stays low. In-window losses during the blanking window are ignored, and the stability count starts after the blanking window ends.
- R4: A critical-fault flag on a good domain clears that domain's power-good on the next clock edge, and a shutdown follows.
- R5: The aggregate power-good is the AND of the three domain power-good outputs. The reset output goes high (released) only after the aggregate has been high for `stable` consecutive cycles, which is 1 + stable cycles after the last domain qualifies.
- R6: A good domain whose in-window flag drops for fewer than `stable` cycles keeps its power-good. It produces a one-cycle warning pulse when the flag returns, and the reset output is unaffected.
- R7: A good domain whose in-window flag stays low for `stable` cycles loses power-good, and a shutdown starts on the following edge.
- R8: A domain that has not reached power-good `timeout` cycles after its enable rose starts a shutdown one cycle later. The fault code records that domain (1 management, 2 core, 3 IO; 0 none), and a one-cycle log pulse is emitted on every shutdown entry.
- R9: Shutdown clears the IO enable on entry, the core enable STEP_DLY cycles later and the management enable STEP_DLY cycles after that. STEP_DLY cycles later still, bring-up restarts if retries remain.
- R10: After RETRY_MAX restarts without reaching the running state, the block locks out with all enables low and emits one more log pulse. Only a clear input leaves the lock-out; the clear also sets the fault code back to 0.
- R11: An external reset request asserts the reset output on the next edge without touching any enable. Release follows `stable` cycles after the request ends.
- R12: Loss of the bus-healthy flag in any active state asserts reset on the next edge and starts an ordered shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ok | input | 1 | Shared bus within its range |
| rail_in_win | input | 3 | Per-domain in-window flags (bit 0 management, 1 core, 2 IO) |
| rail_crit | input | 3 | Per-domain critical-fault flags |
| ext_rst_req | input | 1 | External request to assert system reset |
| fault_clear | input | 1 | Leaves the lock-out state |
| cfg_blank | input | CW | Blanking window in ticks |
| cfg_stable | input | CW | Stability interval in ticks (at least 1) |
| cfg_timeout | input | CW | Bring-up timeout in ticks |
| rail_en | output | 3 | Per-domain enables |
| rail_pg | output | 3 | Per-domain filtered power-good |
| pg_all | output | 1 | Aggregate power-good |
| sys_rst_n | output | 1 | Active-low system reset |
| fault_code | output | 2 | Domain that timed out |
| log_pulse | output | 1 | One-cycle evidence trigger |
| warn_pulse | output | 1 | One-cycle short-dip warning |

## Verification
The bench first drives a clean bring-up, which checks the dependency order and the exact blank-plus-stable and settle timing between output changes. Four disturbances follow from the running state. A two-cycle dip must stay invisible. A one-cycle external request must touch only reset. A critical flag must drop power-good at once. A held-low core flag must escalate, through the sustained-drop path and two core timeouts, into the lock-out. A clear is then followed by a bus loss. Each of these produces a different sequence of output snapshots, and the bench matches that sequence in order and by cycle gap. The ordering separates IO-first from management-first shutdown, and the gaps separate blanking from stability timing.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    localparam int NRAIL = 3;
    localparam int RAIL_MGMT = 0;
    localparam int RAIL_CORE = 1;
    localparam int RAIL_IO   = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MGMT   = 3'd1,
        ST_CIO    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_RUN    = 3'd4,
        ST_SHUT   = 3'd5,
        ST_LATCH  = 3'd6
    } seq_state_e;

    localparam logic [1:0] CODE_NONE = 2'd0;
    localparam logic [1:0] CODE_MGMT = 2'd1;
    localparam logic [1:0] CODE_CORE = 2'd2;
    localparam logic [1:0] CODE_IO   = 2'd3;
endpackage

// File: rtl/rseq_rail_filter.sv
module rseq_rail_filter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_win,
    input  logic          crit,
    input  logic [CW-1:0] cfg_blank,
    input  logic [CW-1:0] cfg_stable,
    input  logic [CW-1:0] cfg_timeout,
    output logic          pg,
    output logic          timed_out,
    output logic          drop,
    output logic          warn
);
    typedef struct packed {
        logic [CW-1:0] bcnt;
        logic [CW-1:0] scnt;
        logic [CW-1:0] tcnt;
        logic [CW-1:0] lcnt;
        logic          pg;
        logic          reached;
        logic          tout;
        logic          drop;
        logic          warn;
    } filt_t;

    filt_t q, d;
    logic  blank_done;

    always_comb begin
        d          = q;
        d.drop     = 1'b0;
        d.warn     = 1'b0;
        blank_done = (q.bcnt >= cfg_blank);
        if (!en) begin
            d = '0;
        end else begin
            if (!blank_done) d.bcnt = q.bcnt + CW'(1);
            // bring-up deadline, only until the first qualification
            if (!q.reached && !q.tout) begin
                if (q.tcnt == cfg_timeout - CW'(1)) d.tout = 1'b1;
                else                                d.tcnt = q.tcnt + CW'(1);
            end
            if (!q.pg) begin
                if (blank_done && in_win && !crit) begin
                    if (q.scnt == cfg_stable - CW'(1)) begin
                        d.pg      = 1'b1;
                        d.reached = 1'b1;
                        d.scnt    = '0;
                    end else begin
                        d.scnt = q.scnt + CW'(1);
                    end
                end else begin
                    d.scnt = '0;
                end
            end else if (crit) begin
                d.pg   = 1'b0;
                d.drop = 1'b1;
                d.lcnt = '0;
            end else if (!in_win) begin
                if (q.lcnt == cfg_stable - CW'(1)) begin
                    d.pg   = 1'b0;
                    d.drop = 1'b1;
                    d.lcnt = '0;
                end else begin
                    d.lcnt = q.lcnt + CW'(1);
                end
            end else begin
                d.warn = (q.lcnt != '0);
                d.lcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pg        = q.pg;
    assign timed_out = q.tout;
    assign drop      = q.drop;
    assign warn      = q.warn;

    // R3
    pg_needs_clean_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pg) |-> ($past(in_win) && !$past(crit) && $past(en)));

    // R4
    crit_clears_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crit && q.pg) |=> !q.pg);
endmodule

// File: rtl/rseq_ctrl.sv
module rseq_ctrl
    import rseq_pkg::*;
#(
    parameter int CW        = 16,
    parameter int STEP_DLY  = 4,
    parameter int RETRY_MAX = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_ok,
    input  logic             ext_rst_req,
    input  logic             fault_clear,
    input  logic [CW-1:0]    cfg_stable,
    input  logic [NRAIL-1:0] pg,
    input  logic [NRAIL-1:0] tout,
    input  logic [NRAIL-1:0] drop,
    output logic [NRAIL-1:0] rail_en,
    output logic             pg_all,
    output logic             sys_rst_n,
    output logic [1:0]       fault_code,
    output logic             log_pulse
);
    localparam int DW = $clog2(STEP_DLY + 1);
    localparam int RW = $clog2(RETRY_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [NRAIL-1:0] en;
        logic [CW-1:0]    sc;
        logic [DW-1:0]    dc;
        logic [RW-1:0]    retry;
        logic [1:0]       code;
        logic             log;
    } ctl_t;

    ctl_t q, d;
    logic active, go_shut;

    assign pg_all = &pg;
    assign active = (q.st == ST_MGMT) || (q.st == ST_CIO) ||
                    (q.st == ST_SETTLE) || (q.st == ST_RUN);

    always_comb begin
        d       = q;
        d.log   = 1'b0;
        go_shut = 1'b0;
        case (q.st)
            ST_IDLE: if (bus_ok) begin
                d.en = 3'b001;
                d.st = ST_MGMT;
            end
            ST_MGMT: if (pg[RAIL_MGMT]) begin
                d.en = 3'b111;
                d.st = ST_CIO;
            end
            ST_CIO: if (pg[RAIL_CORE] && pg[RAIL_IO]) begin
                d.st = ST_SETTLE;
                d.sc = '0;
            end
            ST_SETTLE: begin
                if (pg_all && !ext_rst_req) begin
                    if (q.sc == cfg_stable - CW'(1)) begin
                        d.st    = ST_RUN;
                        d.retry = '0;
                    end else begin
                        d.sc = q.sc + CW'(1);
                    end
                end else begin
                    d.sc = '0;
                end
            end
            ST_RUN: if (ext_rst_req) begin
                d.st = ST_SETTLE;
                d.sc = '0;
            end
            ST_SHUT: begin
                if (q.dc == DW'(STEP_DLY - 1)) begin
                    d.dc = '0;
                    if (q.en[RAIL_CORE])      d.en[RAIL_CORE] = 1'b0;
                    else if (q.en[RAIL_MGMT]) d.en[RAIL_MGMT] = 1'b0;
                    else if (q.retry < RW'(RETRY_MAX)) begin
                        d.retry = q.retry + RW'(1);
                        d.st    = ST_IDLE;
                    end else begin
                        d.st  = ST_LATCH;
                        d.log = 1'b1;
                    end
                end else begin
                    d.dc = q.dc + DW'(1);
                end
            end
            ST_LATCH: if (fault_clear) begin
                d.st    = ST_IDLE;
                d.retry = '0;
                d.code  = CODE_NONE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (active) begin
            if (|tout) begin
                go_shut = 1'b1;
                d.code  = tout[RAIL_MGMT] ? CODE_MGMT :
                          tout[RAIL_CORE] ? CODE_CORE : CODE_IO;
            end else if (!bus_ok || (|drop)) begin
                go_shut = 1'b1;
            end
        end
        if (go_shut) begin
            d.st          = ST_SHUT;
            d.en[RAIL_IO] = 1'b0;
            d.dc          = '0;
            d.log         = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rail_en    = q.en;
    assign sys_rst_n  = (q.st == ST_RUN);
    assign fault_code = q.code;
    assign log_pulse  = q.log;

    // R2
    mgmt_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.en[RAIL_MGMT]) |-> $past(bus_ok));

    // R2
    core_needs_mgmt_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.en[RAIL_CORE]) |-> $past(pg[RAIL_MGMT]));

    // R5
    release_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_RUN) |-> pg_all);

    // R9
    mgmt_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.en[RAIL_MGMT]) |-> (q.en[RAIL_IO:RAIL_CORE] == 2'b00));

    // R10
    latch_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LATCH) |-> (q.en == '0));

    // R12
    bus_loss_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && !bus_ok) |=> (q.st == ST_SHUT));
endmodule

// File: rtl/rail_seq_supervisor.sv
module rail_seq_supervisor
    import rseq_pkg::*;
#(
    parameter int CW        = 16,
    parameter int STEP_DLY  = 4,
    parameter int RETRY_MAX = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ok,
    input  logic [2:0]    rail_in_win,
    input  logic [2:0]    rail_crit,
    input  logic          ext_rst_req,
    input  logic          fault_clear,
    input  logic [CW-1:0] cfg_blank,
    input  logic [CW-1:0] cfg_stable,
    input  logic [CW-1:0] cfg_timeout,
    output logic [2:0]    rail_en,
    output logic [2:0]    rail_pg,
    output logic          pg_all,
    output logic          sys_rst_n,
    output logic [1:0]    fault_code,
    output logic          log_pulse,
    output logic          warn_pulse
);
    logic [NRAIL-1:0] tout_v, drop_v, warn_v;

    for (genvar i = 0; i < NRAIL; i++) begin : g_rail
        rseq_rail_filter #(.CW(CW)) u_filt (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (rail_en[i]),
            .in_win      (rail_in_win[i]),
            .crit        (rail_crit[i]),
            .cfg_blank   (cfg_blank),
            .cfg_stable  (cfg_stable),
            .cfg_timeout (cfg_timeout),
            .pg          (rail_pg[i]),
            .timed_out   (tout_v[i]),
            .drop        (drop_v[i]),
            .warn        (warn_v[i])
        );
    end

    rseq_ctrl #(.CW(CW), .STEP_DLY(STEP_DLY), .RETRY_MAX(RETRY_MAX)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_ok      (bus_ok),
        .ext_rst_req (ext_rst_req),
        .fault_clear (fault_clear),
        .cfg_stable  (cfg_stable),
        .pg          (rail_pg),
        .tout        (tout_v),
        .drop        (drop_v),
        .rail_en     (rail_en),
        .pg_all      (pg_all),
        .sys_rst_n   (sys_rst_n),
        .fault_code  (fault_code),
        .log_pulse   (log_pulse)
    );

    assign warn_pulse = |warn_v;
endmodule

// File: tb/rail_seq_supervisor_tb.sv
module rail_seq_supervisor_tb;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_ok = 1'b0;
    logic [2:0] rail_in_win = 3'b000;
    logic [2:0] rail_crit = 3'b000;
    logic ext_rst_req = 1'b0;
    logic fault_clear = 1'b0;
    logic [CW-1:0] cfg_blank = 16'd3;
    logic [CW-1:0] cfg_stable = 16'd4;
    logic [CW-1:0] cfg_timeout = 16'd20;
    logic [2:0] rail_en, rail_pg;
    logic pg_all, sys_rst_n, log_pulse, warn_pulse;
    logic [1:0] fault_code;

    always #2.5 clk = ~clk;

    rail_seq_supervisor #(.CW(CW), .STEP_DLY(4), .RETRY_MAX(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok), .rail_in_win(rail_in_win),
        .rail_crit(rail_crit), .ext_rst_req(ext_rst_req), .fault_clear(fault_clear),
        .cfg_blank(cfg_blank), .cfg_stable(cfg_stable), .cfg_timeout(cfg_timeout),
        .rail_en(rail_en), .rail_pg(rail_pg), .pg_all(pg_all), .sys_rst_n(sys_rst_n),
        .fault_code(fault_code), .log_pulse(log_pulse), .warn_pulse(warn_pulse)
    );

    typedef struct {
        logic [9:0] snap;
        int         gap;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_cyc = 0;
    int warn_cnt = 0;
    int log_cnt = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    logic [9:0] prev_snap;
    exp_t it;

    wire [9:0] snap = {rail_en, rail_pg, pg_all, sys_rst_n, fault_code};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    // driver side: expected snapshot {en, pg, all, rst_n, code}, cycle gap from previous change
    task automatic push(input logic [2:0] en, input logic [2:0] pg, input logic all,
                        input logic rst, input logic [1:0] code, input int gap, input string req);
        exp_t e;
        e.snap = {en, pg, all, rst, code};
        e.gap  = gap;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic push_bringup(input int first_gap, input string req);
        push(3'b001, 3'b000, 1'b0, 1'b0, 2'd0, first_gap, req);
        push(3'b001, 3'b001, 1'b0, 1'b0, 2'd0, 7, "R3");
        push(3'b111, 3'b001, 1'b0, 1'b0, 2'd0, 1, "R2");
        push(3'b111, 3'b111, 1'b1, 1'b0, 2'd0, 7, "R3");
        push(3'b111, 3'b111, 1'b1, 1'b1, 2'd0, 5, "R5");
    endtask

    // one retry attempt in which core never qualifies
    task automatic push_core_timeout(input logic [1:0] pre_code);
        push(3'b001, 3'b000, 1'b0, 1'b0, pre_code, 4, "R9");
        push(3'b001, 3'b001, 1'b0, 1'b0, pre_code, 7, "R3");
        push(3'b111, 3'b001, 1'b0, 1'b0, pre_code, 1, "R2");
        push(3'b111, 3'b101, 1'b0, 1'b0, pre_code, 7, "R3");
        push(3'b011, 3'b101, 1'b0, 1'b0, 2'd2, 14, "R8");
        push(3'b011, 3'b001, 1'b0, 1'b0, 2'd2, 1, "R9");
        push(3'b001, 3'b001, 1'b0, 1'b0, 2'd2, 3, "R9");
        push(3'b000, 3'b001, 1'b0, 1'b0, 2'd2, 4, "R9");
        push(3'b000, 3'b000, 1'b0, 1'b0, 2'd2, 1, "R9");
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor side: pop and compare on every output change
    always @(negedge clk) begin
        if (mon_on) begin
            if (snap != prev_snap) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected change act=%b exp=%b (R6)", snap, prev_snap);
                end else begin
                    it = exp_q.pop_front();
                    if (it.snap != snap || (it.gap != 0 && it.gap != cyc - last_cyc)) begin
                        errors++;
                        $display("FAIL %s snap act=%b exp=%b gap act=%0d exp=%0d",
                                 it.req, snap, it.snap, cyc - last_cyc, it.gap);
                    end
                end
                prev_snap = snap;
                last_cyc  = cyc;
            end
            if (warn_pulse) warn_cnt++;
            if (log_pulse) log_cnt++;
        end
    end

    initial begin
        int log0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1
        chk(rail_en == 3'b000, "R1", rail_en, 0);
        chk(rail_pg == 3'b000 && !pg_all, "R1", rail_pg, 0);
        chk(sys_rst_n == 1'b0, "R1", sys_rst_n, 0);
        chk(fault_code == 2'd0 && !log_pulse && !warn_pulse, "R1", fault_code, 0);
        prev_snap = snap;
        last_cyc  = cyc;
        mon_on    = 1'b1;

        // clean bring-up (R2 R3 R5)
        push_bringup(0, "R2");
        bus_ok = 1'b1;
        rail_in_win = 3'b111;
        wait_cyc(40);
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);

        // short dip on core: warning only (R6)
        rail_in_win[1] = 1'b0;
        wait_cyc(2);
        rail_in_win[1] = 1'b1;
        wait_cyc(10);
        chk(warn_cnt == 1, "R6", warn_cnt, 1);
        chk(sys_rst_n == 1'b1, "R6", sys_rst_n, 1);

        // external reset request (R11)
        push(3'b111, 3'b111, 1'b1, 1'b0, 2'd0, 0, "R11");
        push(3'b111, 3'b111, 1'b1, 1'b1, 2'd0, 4, "R11");
        ext_rst_req = 1'b1;
        wait_cyc(1);
        ext_rst_req = 1'b0;
        wait_cyc(15);
        chk(rail_en == 3'b111, "R11", rail_en, 7);

        // critical fault on management (R4 R9)
        log0 = log_cnt;
        push(3'b111, 3'b110, 1'b0, 1'b1, 2'd0, 0, "R4");
        push(3'b011, 3'b110, 1'b0, 1'b0, 2'd0, 1, "R4");
        push(3'b011, 3'b010, 1'b0, 1'b0, 2'd0, 1, "R9");
        push(3'b001, 3'b010, 1'b0, 1'b0, 2'd0, 3, "R9");
        push(3'b001, 3'b000, 1'b0, 1'b0, 2'd0, 1, "R9");
        push(3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 3, "R9");
        push_bringup(5, "R9");
        rail_crit[0] = 1'b1;
        wait_cyc(1);
        while (rail_en != 3'b000) @(negedge clk);
        rail_crit[0] = 1'b0;
        wait_cyc(60);
        chk(log_cnt == log0 + 1, "R8", log_cnt, log0 + 1);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

        // sustained core loss, then two core timeouts, then lock-out (R7 R8 R10)
        log0 = log_cnt;
        push(3'b111, 3'b101, 1'b0, 1'b1, 2'd0, 0, "R7");
        push(3'b011, 3'b101, 1'b0, 1'b0, 2'd0, 1, "R7");
        push(3'b011, 3'b001, 1'b0, 1'b0, 2'd0, 1, "R9");
        push(3'b001, 3'b001, 1'b0, 1'b0, 2'd0, 3, "R9");
        push(3'b000, 3'b001, 1'b0, 1'b0, 2'd0, 4, "R9");
        push(3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 1, "R9");
        push_core_timeout(2'd0);
        push_core_timeout(2'd2);
        rail_in_win[1] = 1'b0;
        wait_cyc(160);
        chk(log_cnt == log0 + 4, "R10", log_cnt, log0 + 4);
        chk(fault_code == 2'd2, "R8", fault_code, 2);
        chk(rail_en == 3'b000 && !sys_rst_n, "R10", rail_en, 0);
        chk(exp_q.size() == 0, "R10", exp_q.size(), 0);

        // clear leaves lock-out and restarts (R10)
        push(3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 0, "R10");
        push_bringup(1, "R10");
        rail_in_win[1] = 1'b1;
        fault_clear = 1'b1;
        wait_cyc(1);
        fault_clear = 1'b0;
        wait_cyc(40);
        chk(sys_rst_n == 1'b1, "R10", sys_rst_n, 1);

        // bus loss (R12)
        push(3'b011, 3'b111, 1'b1, 1'b0, 2'd0, 0, "R12");
        push(3'b011, 3'b011, 1'b0, 1'b0, 2'd0, 1, "R12");
        push(3'b001, 3'b011, 1'b0, 1'b0, 2'd0, 3, "R9");
        push(3'b001, 3'b001, 1'b0, 1'b0, 2'd0, 1, "R9");
        push(3'b000, 3'b001, 1'b0, 1'b0, 2'd0, 3, "R9");
        push(3'b000, 3'b000, 1'b0, 1'b0, 2'd0, 1, "R12");
        bus_ok = 1'b0;
        wait_cyc(40);
        chk(rail_en == 3'b000 && !sys_rst_n, "R12", rail_en, 0);
        chk(exp_q.size() == 0, "R12", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule